// File: doc/BRIEF.md
# Prescaled Match/Capture Timer

This block is a 32-bit up-counter that software programs through a small word-addressed register port. A prescale counter sits in front of the main count. It climbs from zero to a programmable terminal value and then clears. Each time it clears, the main count advances by one, so the count moves once every terminal-plus-one clocks. Software can load both counters at any time, can start or stop counting, and can hold both counters at zero.

Four compare channels watch the count. A channel reaches a match on the prescale wrap in which the count equals that channel's compare value. On a match, the channel can do any mix of three things: raise its interrupt flag, send the count back to zero, or stop counting by clearing the enable bit.

Four capture inputs pass through a two-stage synchronizer and then an edge detector. On a selected edge, a channel copies the current count into its own read-only capture register, and it can raise an interrupt flag. All eight flags sit in one register. Software clears a flag by writing one to its bit. A single interrupt pin is high while any flag is set.

Top module: `mtim_timer`

The register port is plain and has no flow control. A write takes effect on the clock edge where `bus_we` is high. Read data is a combinational function of `bus_addr`. The capture inputs are level signals that the block samples every clock.

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: With the prescale terminal at 0 and the enable bit (control word 0x04, bit 0) set, the count rises by one each clock. With the enable bit clear, both counters hold their values.
- R3: The prescale counter (word 0x10) steps from 0 up to the terminal value (word 0x0C). On the next clock it returns to 0 and the count (word 0x08) rises by one. A count of N therefore takes N*(terminal+1) clocks.
- R4: Software can write the count, the prescale counter and the terminal value, and reads return the written values.
- R5: While the hold bit (control bit 1) is set, the count and the prescale counter stay at zero, and bus writes to them have no effect.
- R6: When the reset action is set for channel k, a match on that channel loads the count with 0 instead of incrementing it. The reset action is bit 3k+1 of the match-action word at 0x14. Channel k compares against the word at 0x18+4k.
- R7: When the stop action is set for channel k (bit 3k+2 of word 0x14), a match leaves the count at the compare value, clears the prescale counter and clears the enable bit.
- R8: When the interrupt action is set for channel k (bit 3k of word 0x14), a match sets flag bit k of the flag word at 0x00. Without that action, no flag is set.
- R9: Writing 1 to a flag bit clears it, and writing 0 leaves it as it was. `irq_o` is the OR of all eight flags.
- R10: Capture channel c loads the count into its read-only register at 0x2C+4c on a rising edge if bit 3c of word 0x28 is set, and on a falling edge if bit 3c+1 is set. Edges that are not selected, and bus writes, leave the capture register unchanged. If bit 3c+2 is also set, the capture sets flag bit 4+c. The capture happens within three clocks of the input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register word |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| cap_in | input | 4 | Asynchronous capture inputs |
| irq_o | output | 1 | OR of all pending flags |

## Verification
The counting path is run three ways: free-running with no prescale, with a terminal of 3, and with the hold bit set. Reading both counters after a known number of clocks distinguishes an off-by-one prescale wrap from a correct one. The compare channels are run with the reset-and-flag combination, and separately with stop on one channel and flag-only on another. Together these show whether each action is applied only to its own channel and only at the wrap. Capture is driven with rising and falling edges against channels that select only one of the two. This exposes swapped edge selects, a missing interrupt gate, and a capture register that accepts bus writes.

// File: rtl/mtim_pkg.sv
package mtim_pkg;
  // per-channel field layout of the match-action word
  localparam int unsigned MF_INT  = 0;
  localparam int unsigned MF_RST  = 1;
  localparam int unsigned MF_STOP = 2;
  localparam int unsigned MF_W    = 3;
  // per-channel field layout of the capture-select word
  localparam int unsigned CF_RISE = 0;
  localparam int unsigned CF_FALL = 1;
  localparam int unsigned CF_INT  = 2;
  localparam int unsigned CF_W    = 3;
  // control bits
  localparam int unsigned CTRL_EN   = 0;
  localparam int unsigned CTRL_HOLD = 1;
  // word indices of the register map
  localparam int unsigned WI_IRQ    = 0;
  localparam int unsigned WI_CTRL   = 1;
  localparam int unsigned WI_COUNT  = 2;
  localparam int unsigned WI_PRE    = 3;
  localparam int unsigned WI_PCNT   = 4;
  localparam int unsigned WI_MCTL   = 5;
  localparam int unsigned WI_MATCH0 = 6;
endpackage

// File: rtl/mtim_sync.sv
module mtim_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] stage1_q, stage2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      prev_q   <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
      prev_q   <= stage2_q;
    end
  end

  assign rise = stage2_q & ~prev_q;
  assign fall = ~stage2_q & prev_q;
endmodule

// File: rtl/mtim_counter.sv
module mtim_counter
  import mtim_pkg::*;
#(
  parameter int CW     = 32,
  parameter int NMATCH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run_en,
  input  logic                       hold,
  input  logic [CW-1:0]              pre,
  input  logic                       wr_count,
  input  logic                       wr_pcnt,
  input  logic [CW-1:0]              wdata,
  input  logic [NMATCH-1:0][CW-1:0]  match_val,
  input  logic [MF_W*NMATCH-1:0]     mctl,
  output logic [CW-1:0]              count,
  output logic [CW-1:0]              pcnt,
  output logic [NMATCH-1:0]          match_int,
  output logic                       stop_req
);
  logic              active, tick;
  logic [NMATCH-1:0] hit, rst_mask, stop_mask, int_mask;
  logic              any_rst;

  assign active = run_en && !hold;
  assign tick   = active && (pcnt == pre);

  for (genvar k = 0; k < NMATCH; k++) begin : g_ch
    assign hit[k]       = tick && (count == match_val[k]);
    assign int_mask[k]  = mctl[MF_W*k + MF_INT];
    assign rst_mask[k]  = mctl[MF_W*k + MF_RST];
    assign stop_mask[k] = mctl[MF_W*k + MF_STOP];
  end

  assign any_rst   = |(hit & rst_mask);
  assign stop_req  = |(hit & stop_mask);
  assign match_int = hit & int_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      pcnt  <= '0;
    end else if (hold) begin
      count <= '0;
      pcnt  <= '0;
    end else begin
      if (wr_count)      count <= wdata;
      else if (tick) begin
        if (any_rst)       count <= '0;
        else if (!stop_req) count <= count + CW'(1);
      end
      if (wr_pcnt)       pcnt <= wdata;
      else if (tick)     pcnt <= '0;
      else if (active)   pcnt <= pcnt + CW'(1);
    end
  end
endmodule

// File: rtl/mtim_capture.sv
module mtim_capture
  import mtim_pkg::*;
#(
  parameter int CW   = 32,
  parameter int NCAP = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCAP-1:0]          rise,
  input  logic [NCAP-1:0]          fall,
  input  logic [CF_W*NCAP-1:0]     cctl,
  input  logic [CW-1:0]            count,
  output logic [NCAP-1:0][CW-1:0]  cap_val,
  output logic [NCAP-1:0]          cap_evt,
  output logic [NCAP-1:0]          cap_int
);
  for (genvar c = 0; c < NCAP; c++) begin : g_cap
    assign cap_evt[c] = (rise[c] && cctl[CF_W*c + CF_RISE]) ||
                        (fall[c] && cctl[CF_W*c + CF_FALL]);
    assign cap_int[c] = cap_evt[c] && cctl[CF_W*c + CF_INT];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cap_val[c] <= '0;
      else if (cap_evt[c]) cap_val[c] <= count;
    end
  end
endmodule

// File: rtl/mtim_timer.sv
module mtim_timer
  import mtim_pkg::*;
#(
  parameter int CW     = 32,
  parameter int NMATCH = 4,
  parameter int NCAP   = 4,
  parameter int AW     = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [CW-1:0]   bus_wdata,
  output logic [CW-1:0]   bus_rdata,
  input  logic [NCAP-1:0] cap_in,
  output logic            irq_o
);
  localparam int NIRQ     = NMATCH + NCAP;
  localparam int WIW      = AW - 2;
  localparam int MCW      = MF_W * NMATCH;
  localparam int CCW      = CF_W * NCAP;
  localparam int WI_CCTL  = WI_MATCH0 + NMATCH;
  localparam int WI_CAP0  = WI_CCTL + 1;

  logic [WIW-1:0]            widx;
  logic                      unused_addr_lsb;
  logic                      ctrl_en, ctrl_hold;
  logic [CW-1:0]             pre_q;
  logic [MCW-1:0]            mctl_q;
  logic [CCW-1:0]            cctl_q;
  logic [NMATCH-1:0][CW-1:0] match_q;
  logic [NIRQ-1:0]           irq_flags, irq_set, irq_clr;
  logic                      wr_irq, wr_ctrl, wr_count, wr_pre, wr_pcnt, wr_mctl, wr_cctl;
  logic [CW-1:0]             count, pcnt;
  logic [NMATCH-1:0]         match_int;
  logic                      stop_req;
  logic [NCAP-1:0]           rise, fall, cap_evt, cap_int;
  logic [NCAP-1:0][CW-1:0]   cap_val;

  assign widx            = bus_addr[AW-1:2];
  assign unused_addr_lsb = ^bus_addr[1:0];

  assign wr_irq   = bus_we && (widx == WIW'(WI_IRQ));
  assign wr_ctrl  = bus_we && (widx == WIW'(WI_CTRL));
  assign wr_count = bus_we && (widx == WIW'(WI_COUNT));
  assign wr_pre   = bus_we && (widx == WIW'(WI_PRE));
  assign wr_pcnt  = bus_we && (widx == WIW'(WI_PCNT));
  assign wr_mctl  = bus_we && (widx == WIW'(WI_MCTL));
  assign wr_cctl  = bus_we && (widx == WIW'(WI_CCTL));

  // control, prescale terminal, action words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      ctrl_hold <= 1'b0;
      pre_q     <= '0;
      mctl_q    <= '0;
      cctl_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_en   <= bus_wdata[CTRL_EN];
        ctrl_hold <= bus_wdata[CTRL_HOLD];
      end else if (stop_req) begin
        ctrl_en   <= 1'b0;
      end
      if (wr_pre)  pre_q  <= bus_wdata;
      if (wr_mctl) mctl_q <= bus_wdata[MCW-1:0];
      if (wr_cctl) cctl_q <= bus_wdata[CCW-1:0];
    end
  end

  // compare values
  for (genvar k = 0; k < NMATCH; k++) begin : g_match
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_q[k] <= '0;
      else if (bus_we && (widx == WIW'(WI_MATCH0 + k))) match_q[k] <= bus_wdata;
    end
  end

  // flags: a new event wins over a clear in the same cycle
  assign irq_set = {cap_int, match_int};
  assign irq_clr = wr_irq ? bus_wdata[NIRQ-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_flags <= '0;
    else        irq_flags <= (irq_flags & ~irq_clr) | irq_set;
  end

  assign irq_o = |irq_flags;

  mtim_counter #(.CW(CW), .NMATCH(NMATCH)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (ctrl_en),
    .hold      (ctrl_hold),
    .pre       (pre_q),
    .wr_count  (wr_count),
    .wr_pcnt   (wr_pcnt),
    .wdata     (bus_wdata),
    .match_val (match_q),
    .mctl      (mctl_q),
    .count     (count),
    .pcnt      (pcnt),
    .match_int (match_int),
    .stop_req  (stop_req)
  );

  mtim_sync #(.N(NCAP)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (cap_in),
    .rise     (rise),
    .fall     (fall)
  );

  mtim_capture #(.CW(CW), .NCAP(NCAP)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise    (rise),
    .fall    (fall),
    .cctl    (cctl_q),
    .count   (count),
    .cap_val (cap_val),
    .cap_evt (cap_evt),
    .cap_int (cap_int)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (widx == WIW'(WI_IRQ))   bus_rdata = CW'(irq_flags);
    if (widx == WIW'(WI_CTRL))  bus_rdata = CW'({ctrl_hold, ctrl_en});
    if (widx == WIW'(WI_COUNT)) bus_rdata = count;
    if (widx == WIW'(WI_PRE))   bus_rdata = pre_q;
    if (widx == WIW'(WI_PCNT))  bus_rdata = pcnt;
    if (widx == WIW'(WI_MCTL))  bus_rdata = CW'(mctl_q);
    if (widx == WIW'(WI_CCTL))  bus_rdata = CW'(cctl_q);
    for (int k = 0; k < NMATCH; k++)
      if (widx == WIW'(WI_MATCH0 + k)) bus_rdata = match_q[k];
    for (int c = 0; c < NCAP; c++)
      if (widx == WIW'(WI_CAP0 + c)) bus_rdata = cap_val[c];
  end
endmodule

// File: rtl/mtim_checker.sv
module mtim_checker #(
  parameter int CW     = 32,
  parameter int NMATCH = 4,
  parameter int NCAP   = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ctrl_en,
  input logic                     ctrl_hold,
  input logic                     wr_ctrl,
  input logic                     wr_count,
  input logic                     wr_pcnt,
  input logic                     wr_irq,
  input logic [NMATCH+NCAP-1:0]   wdata_irq,
  input logic [CW-1:0]            count,
  input logic [CW-1:0]            pcnt,
  input logic [CW-1:0]            pre,
  input logic                     stop_req,
  input logic [NMATCH+NCAP-1:0]   irq_set,
  input logic [NMATCH+NCAP-1:0]   irq_flags,
  input logic [NCAP-1:0]          cap_evt,
  input logic [NCAP-1:0][CW-1:0]  cap_val
);
  p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !ctrl_hold && !wr_count && !wr_pcnt) |=> ($stable(count) && $stable(pcnt)));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && !ctrl_hold && (pcnt == pre) && !wr_pcnt) |=> (pcnt == '0));

  p_hold_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hold |=> ((count == '0) && (pcnt == '0)));

  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !wr_ctrl) |=> !ctrl_en);

  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_set) |=> ((irq_flags & $past(irq_set)) == $past(irq_set)));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_irq |=> ((irq_flags & $past(wdata_irq) & ~$past(irq_set)) == '0));

  for (genvar c = 0; c < NCAP; c++) begin : g_cap
    p_cap_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[c] |=> (cap_val[c] == $past(count)));
  end
endmodule

bind mtim_timer mtim_checker #(.CW(CW), .NMATCH(NMATCH), .NCAP(NCAP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_en   (ctrl_en),
  .ctrl_hold (ctrl_hold),
  .wr_ctrl   (wr_ctrl),
  .wr_count  (wr_count),
  .wr_pcnt   (wr_pcnt),
  .wr_irq    (wr_irq),
  .wdata_irq (bus_wdata[NMATCH+NCAP-1:0]),
  .count     (count),
  .pcnt      (pcnt),
  .pre       (pre_q),
  .stop_req  (stop_req),
  .irq_set   (irq_set),
  .irq_flags (irq_flags),
  .cap_evt   (cap_evt),
  .cap_val   (cap_val)
);

// File: tb/mtim_timer_bench.sv
module mtim_timer_bench;
  localparam int CLK_NS = 10;
  localparam logic [7:0] A_IRQ = 8'h00, A_CTRL = 8'h04, A_COUNT = 8'h08, A_PRE = 8'h0C,
                         A_PCNT = 8'h10, A_MCTL = 8'h14, A_M0 = 8'h18, A_M1 = 8'h1C,
                         A_M2 = 8'h20, A_CCTL = 8'h28, A_CAP0 = 8'h2C, A_CAP1 = 8'h30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  cap_in = '0;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] exp;
    logic [7:0]  addr;
    bit          pin;
    string       tag;
  } item_t;
  item_t sbq[$];
  event  rd_ev;

  always #(CLK_NS/2) clk = ~clk;

  mtim_timer u_mtim_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in), .irq_o(irq_o)
  );

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    it.exp = e; it.addr = a; it.pin = 1'b0; it.tag = tag;
    sbq.push_back(it);
    -> rd_ev;
    #2;
  endtask

  task automatic pin(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = {31'b0, e}; it.addr = 8'hFF; it.pin = 1'b1; it.tag = tag;
    sbq.push_back(it);
    -> rd_ev;
    #2;
  endtask

  // monitor: pops expected items and compares against the design
  initial begin
    forever begin
      item_t it;
      logic [31:0] act;
      @(rd_ev);
      #1;
      it = sbq.pop_front();
      act = it.pin ? {31'b0, irq_o} : bus_rdata;
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, act, it.exp);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    rd(A_IRQ, 0, "R1"); rd(A_CTRL, 0, "R1"); rd(A_COUNT, 0, "R1");
    rd(A_PRE, 0, "R1"); rd(A_PCNT, 0, "R1"); rd(A_MCTL, 0, "R1");
    rd(A_M0, 0, "R1"); rd(A_CCTL, 0, "R1"); rd(A_CAP0, 0, "R1");
    pin(1'b0, "R1");

    // R4: readback of loaded counters
    wr(A_COUNT, 32'hDEAD0000); rd(A_COUNT, 32'hDEAD0000, "R4");
    wr(A_PCNT, 32'h1F);        rd(A_PCNT, 32'h1F, "R4");
    wr(A_PRE, 32'h77);         rd(A_PRE, 32'h77, "R4");
    wr(A_PRE, 0); wr(A_PCNT, 0);

    // R2: free count, 10 clocks with enable high
    wr(A_COUNT, 0);
    wr(A_CTRL, 1);
    repeat (9) @(posedge clk);
    wr(A_CTRL, 0);
    rd(A_COUNT, 10, "R2");
    repeat (3) @(posedge clk);
    rd(A_COUNT, 10, "R2");

    // R3: terminal 3, 10 clocks -> count 2, prescale 2
    wr(A_PRE, 3); wr(A_COUNT, 0); wr(A_PCNT, 0);
    wr(A_CTRL, 1);
    repeat (9) @(posedge clk);
    wr(A_CTRL, 0);
    rd(A_COUNT, 2, "R3"); rd(A_PCNT, 2, "R3");

    // R5: hold keeps both zero, ignores writes
    wr(A_CTRL, 3);
    repeat (3) @(posedge clk);
    rd(A_COUNT, 0, "R5"); rd(A_PCNT, 0, "R5");
    wr(A_COUNT, 7);
    rd(A_COUNT, 0, "R5");
    wr(A_CTRL, 0);
    wr(A_PRE, 0); wr(A_PCNT, 0); wr(A_COUNT, 0);

    // R6/R8: channel 0 reset+flag at 5; 10 clocks -> count 4
    wr(A_M0, 5); wr(A_MCTL, 32'h3);
    wr(A_CTRL, 1);
    repeat (9) @(posedge clk);
    wr(A_CTRL, 0);
    rd(A_COUNT, 4, "R6");
    rd(A_IRQ, 32'h1, "R8");
    pin(1'b1, "R9");
    // R9: write 0 keeps, write 1 clears
    wr(A_IRQ, 0);
    rd(A_IRQ, 32'h1, "R9");
    wr(A_IRQ, 1);
    rd(A_IRQ, 0, "R9");
    pin(1'b0, "R9");

    // R7/R8: ch1 stop at 3, ch2 flag-only at 2
    wr(A_COUNT, 0); wr(A_M1, 3); wr(A_M2, 2); wr(A_MCTL, 32'h60);
    wr(A_CTRL, 1);
    repeat (9) @(posedge clk);
    rd(A_CTRL, 0, "R7");
    rd(A_COUNT, 3, "R7");
    rd(A_IRQ, 32'h4, "R8");
    wr(A_IRQ, 32'hFF);
    wr(A_MCTL, 0);

    // R10: capture edge selection
    wr(A_COUNT, 32'h1234);
    wr(A_CCTL, 32'h15);
    wr(A_IRQ, 32'hFF);
    @(negedge clk) cap_in[0] = 1'b1;
    repeat (4) @(posedge clk);
    rd(A_CAP0, 32'h1234, "R10");
    rd(A_IRQ, 32'h10, "R10");
    @(negedge clk) cap_in[1] = 1'b1;
    repeat (4) @(posedge clk);
    rd(A_CAP1, 0, "R10");
    wr(A_COUNT, 32'h55);
    @(negedge clk) cap_in[1] = 1'b0;
    repeat (4) @(posedge clk);
    rd(A_CAP1, 32'h55, "R10");
    rd(A_IRQ, 32'h10, "R10");
    @(negedge clk) cap_in[0] = 1'b0;
    repeat (4) @(posedge clk);
    rd(A_CAP0, 32'h1234, "R10");
    wr(A_CAP0, 32'h999);
    rd(A_CAP0, 32'h1234, "R10");
    pin(1'b1, "R9");

    repeat (2) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule